// File: doc/BRIEF.md
# Conditional Branch and Loop Evaluator

This unit decides, once per evaluation request, whether a conditional control transfer is taken. The request carries a two-bit operation kind and a four-bit condition selector. The unit samples four arithmetic flags: carry, zero, sign and overflow. It also holds a counter register of its own. The counter can be written through a load port.

The unit supports four operation kinds:
- Flag-conditioned jumps. These cover single-flag tests, unsigned comparisons and signed comparisons.
- A jump that is taken when the counter is zero. This operation leaves the counter as it is.
- Three loop forms. Each loop form decrements the counter on the same edge on which its decision is registered.

The decision and a result strobe appear one cycle after the request. Target addresses, decoding beyond the selector, and pipeline redirection are left to the surrounding logic.

Top module: `branch_loop_eval`

## Requirements
- R1: While `rst_n` is low, and until the first request after reset, `counter`, `branch_taken` and `result_valid` are all 0.
- R2: The request is presented in cycle N and registered on the following rising edge. `result_valid` is 1 after that edge exactly when `eval_valid` was 1 in cycle N. `branch_taken` is never 1 while `result_valid` is 0.
- R3: With `op_kind` = 0 (flag jump), the single-flag selectors decide the branch as follows:
  - 0: taken when CF=1.
  - 1: taken when CF=0.
  - 2: taken when ZF=1.
  - 3: taken when ZF=0.
  - 4: taken when SF=1.
  - 5: taken when SF=0.
  - 6: taken when OF=1.
  - 7: taken when OF=0.
- R4: With `op_kind` = 0, the unsigned selectors decide the branch as follows:
  - 8 (above): taken when CF=0 and ZF=0.
  - 9 (below or equal): taken when CF=1 or ZF=1.
- R5: With `op_kind` = 0, the signed selectors decide the branch as follows:
  - 10 (less): taken when SF differs from OF.
  - 11 (greater or equal): taken when SF equals OF.
  - 12 (less or equal): taken when ZF=1 or SF differs from OF.
  - 13 (greater): taken when ZF=0 and SF equals OF.
- R6: With `op_kind` = 0, selector 14 is always taken and selector 15 is never taken.
- R7: With `op_kind` = 1 (counter-zero jump), the branch is taken exactly when `counter` is 0, and `counter` keeps its value.
- R8: With `op_kind` = 2 and selector 0 (plain loop), `counter` becomes `counter`-1, and the branch is taken when that new value is nonzero. A counter of 0 wraps to all ones, and the branch is then taken.
- R9: With `op_kind` = 2 and selector 1 (loop while zero), `counter` is decremented, and the branch is taken only when the new value is nonzero and ZF=1.
- R10: With `op_kind` = 2 and selector 2 (loop while not zero), `counter` is decremented, and the branch is taken only when the new value is nonzero and ZF=0.
- R11: The following requests are never taken and leave `counter` unchanged:
  - `op_kind` = 3, with any selector.
  - `op_kind` = 2 with a selector of 3 or above.
  - Flag jumps never modify `counter`.
- R12: When `cnt_load` is 1, `counter` takes `cnt_load_val` on the next edge, even if a loop request is present in the same cycle. The decision of that loop request is still based on the counter value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_load | input | 1 | Write the counter from `cnt_load_val` |
| cnt_load_val | input | CNT_W | Value written to the counter |
| eval_valid | input | 1 | Evaluation request in this cycle |
| op_kind | input | 2 | 0 flag jump, 1 counter-zero jump, 2 loop, 3 unused |
| cond_sel | input | 4 | Condition selector or loop form |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| result_valid | output | 1 | Decision registered for last cycle's request |
| branch_taken | output | 1 | Registered branch decision |
| counter | output | CNT_W | Current counter register |

## Verification
Every flag-jump selector is applied under all sixteen combinations of the four flags. This exposes any selector that reads the wrong flag, inverts a flag, or uses AND where OR is needed. The loop forms are run down from small preloaded counts in two flag states:
- ZF set and ZF clear. This separates the two zero-conditioned forms from each other and from the plain loop.
- A final step to zero. This shows that a decrement reaching zero is not taken.

A loop from zero shows the wrap to all ones. The counter-zero jump is tried with zero and nonzero counts. The unused encodings are tried with a nonzero count to show that they neither branch nor touch the counter. A simultaneous load and loop request shows which write wins and which counter value the decision uses.

// File: rtl/branch_loop_eval.sv
module branch_loop_eval #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             eval_valid,
  input  logic [1:0]       op_kind,
  input  logic [3:0]       cond_sel,
  input  logic             flag_cf,
  input  logic             flag_zf,
  input  logic             flag_sf,
  input  logic             flag_of,
  output logic             result_valid,
  output logic             branch_taken,
  output logic [CNT_W-1:0] counter
);

  localparam logic [1:0] OP_FLAG  = 2'd0;
  localparam logic [1:0] OP_CZERO = 2'd1;
  localparam logic [1:0] OP_LOOP  = 2'd2;

  localparam logic [3:0] LP_PLAIN = 4'd0;
  localparam logic [3:0] LP_WZ    = 4'd1;
  localparam logic [3:0] LP_WNZ   = 4'd2;

  logic             sgn_lt;
  logic             flag_hit;
  logic [CNT_W-1:0] cnt_dec;
  logic             dec_nz;
  logic             loop_form;
  logic             hit;

  assign sgn_lt    = flag_sf ^ flag_of;
  assign cnt_dec   = counter - 1'b1;
  assign dec_nz    = |cnt_dec;
  assign loop_form = (op_kind == OP_LOOP) && (cond_sel <= LP_WNZ);

  always_comb begin
    unique case (cond_sel)
      4'd0:    flag_hit = flag_cf;
      4'd1:    flag_hit = ~flag_cf;
      4'd2:    flag_hit = flag_zf;
      4'd3:    flag_hit = ~flag_zf;
      4'd4:    flag_hit = flag_sf;
      4'd5:    flag_hit = ~flag_sf;
      4'd6:    flag_hit = flag_of;
      4'd7:    flag_hit = ~flag_of;
      4'd8:    flag_hit = ~flag_cf & ~flag_zf;
      4'd9:    flag_hit = flag_cf | flag_zf;
      4'd10:   flag_hit = sgn_lt;
      4'd11:   flag_hit = ~sgn_lt;
      4'd12:   flag_hit = flag_zf | sgn_lt;
      4'd13:   flag_hit = ~flag_zf & ~sgn_lt;
      4'd14:   flag_hit = 1'b1;
      default: flag_hit = 1'b0;
    endcase
  end

  always_comb begin
    hit = 1'b0;
    case (op_kind)
      OP_FLAG:  hit = flag_hit;
      OP_CZERO: hit = (counter == '0);
      OP_LOOP: begin
        case (cond_sel)
          LP_PLAIN: hit = dec_nz;
          LP_WZ:    hit = dec_nz & flag_zf;
          LP_WNZ:   hit = dec_nz & ~flag_zf;
          default:  hit = 1'b0;
        endcase
      end
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      branch_taken <= 1'b0;
      counter      <= '0;
    end else begin
      result_valid <= eval_valid;
      branch_taken <= eval_valid & hit;
      if (cnt_load)
        counter <= cnt_load_val;
      else if (eval_valid && loop_form)
        counter <= cnt_dec;
    end
  end

endmodule

// File: rtl/branch_loop_eval_chk.sv
module branch_loop_eval_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt_load_val,
  input logic             eval_valid,
  input logic [1:0]       op_kind,
  input logic [3:0]       cond_sel,
  input logic             flag_zf,
  input logic             result_valid,
  input logic             branch_taken,
  input logic [CNT_W-1:0] counter
);

  assert_taken_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |-> result_valid);

  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_valid |=> !result_valid);

  assert_czero_keeps_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && op_kind == 2'd1 && !cnt_load) |=> $stable(counter));

  assert_loop_decrements_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && op_kind == 2'd2 && cond_sel <= 4'd2 && !cnt_load)
      |=> counter == $past(counter) - 1'b1);

  assert_loop_zero_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && op_kind == 2'd2 && !cnt_load) |=> !(branch_taken && counter == '0));

  assert_wz_needs_zf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && op_kind == 2'd2 && cond_sel == 4'd1 && !flag_zf) |=> !branch_taken);

  assert_wnz_needs_nzf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && op_kind == 2'd2 && cond_sel == 4'd2 && flag_zf) |=> !branch_taken);

  assert_unused_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_valid && !cnt_load && (op_kind == 2'd3 || (op_kind == 2'd2 && cond_sel > 4'd2)))
      |=> (!branch_taken && $stable(counter)));

  assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> counter == $past(cnt_load_val));

endmodule

bind branch_loop_eval branch_loop_eval_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_load     (cnt_load),
  .cnt_load_val (cnt_load_val),
  .eval_valid   (eval_valid),
  .op_kind      (op_kind),
  .cond_sel     (cond_sel),
  .flag_zf      (flag_zf),
  .result_valid (result_valid),
  .branch_taken (branch_taken),
  .counter      (counter)
);

// File: tb/branch_loop_eval_tb.sv
module branch_loop_eval_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cnt_load;
  logic [W-1:0] cnt_load_val;
  logic         eval_valid;
  logic [1:0]   op_kind;
  logic [3:0]   cond_sel;
  logic         flag_cf, flag_zf, flag_sf, flag_of;
  logic         result_valid, branch_taken;
  logic [W-1:0] counter;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  branch_loop_eval #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .eval_valid(eval_valid), .op_kind(op_kind), .cond_sel(cond_sel),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of),
    .result_valid(result_valid), .branch_taken(branch_taken), .counter(counter)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit flag_model(input logic [3:0] s, input bit cf, input bit zf,
                                    input bit sf, input bit of_f);
    case (s)
      4'd0:  return cf;
      4'd1:  return !cf;
      4'd2:  return zf;
      4'd3:  return !zf;
      4'd4:  return sf;
      4'd5:  return !sf;
      4'd6:  return of_f;
      4'd7:  return !of_f;
      4'd8:  return !cf && !zf;
      4'd9:  return cf || zf;
      4'd10: return sf != of_f;
      4'd11: return sf == of_f;
      4'd12: return zf || (sf != of_f);
      4'd13: return !zf && (sf == of_f);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step_eval(input logic [1:0] op, input logic [3:0] sel, input logic [3:0] fl);
    eval_valid = 1'b1;
    op_kind    = op;
    cond_sel   = sel;
    {flag_cf, flag_zf, flag_sf, flag_of} = fl;
    @(negedge clk);
    eval_valid = 1'b0;
  endtask

  task automatic load_cnt(input logic [W-1:0] v);
    cnt_load = 1'b1;
    cnt_load_val = v;
    @(negedge clk);
    cnt_load = 1'b0;
    chk("R12 load", counter, v);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 counter", counter, '0);
    chk("R1 taken", {31'b0, branch_taken}, 0);
    chk("R1 valid", {31'b0, result_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 counter after release", counter, '0);
    chk("R2 idle valid", {31'b0, result_valid}, 0);
  endtask

  task automatic t_flags;
    load_cnt(32'h55);
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        logic [3:0] fl;
        string tag;
        fl = f[3:0];
        step_eval(2'd0, s[3:0], fl);
        tag = (s < 8) ? "R3" : (s < 10) ? "R4" : (s < 14) ? "R5" : "R6";
        chk({tag, " flag jump taken"}, {31'b0, branch_taken},
            {31'b0, flag_model(s[3:0], fl[3], fl[2], fl[1], fl[0])});
        chk("R2 valid after request", {31'b0, result_valid}, 1);
      end
    end
    chk("R11 flag jumps keep counter", counter, 32'h55);
    @(negedge clk);
    chk("R2 valid low when idle", {31'b0, result_valid}, 0);
    chk("R2 taken low when idle", {31'b0, branch_taken}, 0);
  endtask

  task automatic t_czero;
    load_cnt('0);
    step_eval(2'd1, 4'd0, 4'b0000);
    chk("R7 zero taken", {31'b0, branch_taken}, 1);
    chk("R7 zero kept", counter, '0);
    load_cnt(7);
    step_eval(2'd1, 4'd0, 4'b0100);
    chk("R7 nonzero not taken", {31'b0, branch_taken}, 0);
    chk("R7 nonzero kept", counter, 7);
  endtask

  task automatic t_loop_plain;
    load_cnt(3);
    step_eval(2'd2, 4'd0, 4'b0000);
    chk("R8 3->2 taken", {31'b0, branch_taken}, 1);
    chk("R8 count 2", counter, 2);
    step_eval(2'd2, 4'd0, 4'b0100);
    chk("R8 2->1 taken", {31'b0, branch_taken}, 1);
    chk("R8 count 1", counter, 1);
    step_eval(2'd2, 4'd0, 4'b0000);
    chk("R8 1->0 not taken", {31'b0, branch_taken}, 0);
    chk("R8 count 0", counter, 0);
    step_eval(2'd2, 4'd0, 4'b0000);
    chk("R8 wrap taken", {31'b0, branch_taken}, 1);
    chk("R8 wrap all ones", counter, '1);
  endtask

  task automatic t_loop_wz;
    load_cnt(5);
    step_eval(2'd2, 4'd1, 4'b0100);
    chk("R9 zf=1 taken", {31'b0, branch_taken}, 1);
    chk("R9 count 4", counter, 4);
    step_eval(2'd2, 4'd1, 4'b0000);
    chk("R9 zf=0 not taken", {31'b0, branch_taken}, 0);
    chk("R9 count 3", counter, 3);
    load_cnt(1);
    step_eval(2'd2, 4'd1, 4'b0100);
    chk("R9 reaches zero not taken", {31'b0, branch_taken}, 0);
    chk("R9 count 0", counter, 0);
  endtask

  task automatic t_loop_wnz;
    load_cnt(5);
    step_eval(2'd2, 4'd2, 4'b0000);
    chk("R10 zf=0 taken", {31'b0, branch_taken}, 1);
    chk("R10 count 4", counter, 4);
    step_eval(2'd2, 4'd2, 4'b0100);
    chk("R10 zf=1 not taken", {31'b0, branch_taken}, 0);
    chk("R10 count 3", counter, 3);
    load_cnt(1);
    step_eval(2'd2, 4'd2, 4'b0000);
    chk("R10 reaches zero not taken", {31'b0, branch_taken}, 0);
    chk("R10 count 0", counter, 0);
  endtask

  task automatic t_unused;
    load_cnt(9);
    for (int s = 0; s < 16; s++) begin
      step_eval(2'd3, s[3:0], 4'b1111);
      chk("R11 op3 not taken", {31'b0, branch_taken}, 0);
      chk("R11 op3 counter kept", counter, 9);
    end
    for (int s = 3; s < 16; s++) begin
      step_eval(2'd2, s[3:0], 4'b0000);
      chk("R11 loop sel unused not taken", {31'b0, branch_taken}, 0);
      chk("R11 loop sel unused counter kept", counter, 9);
    end
  endtask

  task automatic t_load_priority;
    load_cnt(1);
    cnt_load = 1'b1;
    cnt_load_val = 32'd20;
    step_eval(2'd2, 4'd0, 4'b0000);
    cnt_load = 1'b0;
    chk("R12 load beats decrement", counter, 20);
    chk("R12 decision from old count", {31'b0, branch_taken}, 0);
    step_eval(2'd2, 4'd0, 4'b0000);
    chk("R12 loop after load", counter, 19);
    chk("R12 loop after load taken", {31'b0, branch_taken}, 1);
  endtask

  initial begin
    rst_n = 1'b0; cnt_load = 1'b0; cnt_load_val = '0; eval_valid = 1'b0;
    op_kind = '0; cond_sel = '0; {flag_cf, flag_zf, flag_sf, flag_of} = '0;
    @(negedge clk);
    t_reset();
    t_flags();
    t_czero();
    t_loop_plain();
    t_loop_wz();
    t_loop_wnz();
    t_unused();
    t_load_priority();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule